// File: doc/BRIEF.md
# Fixed-Latency Writeback Scheduler

This block holds the register state of an exposed-pipeline processor that has no interlocks. Every cycle up to `NUM_ISSUE` operations arrive, each with a class, a destination register and an already computed result. The block never stalls and never checks dependencies. Instead it delays each register-file write by a fixed number of delay slots chosen by the class. Until a write lands, any read of that register returns the previous contents. Software is expected to schedule dependent operations around these latencies.

Branches use the same mechanism. A branch carries its target in the value field. The program counter keeps stepping by one through the branch's delay slots and then jumps to the target. Only one branch can be pending at a time: a newer branch replaces the pending target and restarts the countdown. When two writes reach the same register at the same clock edge, the one issued later is kept and a one-cycle collision flag is raised.

Top module: `lat_wb_sched`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register is cleared to 0, `pc` is loaded with `RESET_PC` and `wr_collision` is cleared.
- R2: An operation of class 0 (single-cycle) is written at the edge that samples it, so a read is already served the new value in the following cycle.
- R3: An operation of class 1 (multiply) has `MUL_SLOTS` delay slots (default 1). Reads in the cycle after issue return the old value, and the new value is visible from the second cycle after issue.
- R4: An operation of class 2 (load) has `LOAD_SLOTS` delay slots (default 4). Reads in the four cycles after issue return the old value, and the new value is visible from the fifth.
- R5: `pc` increments by 1 every cycle. If a class 3 (branch) operation is issued in a cycle where `pc` is P, the next `BR_SLOTS` cycles (default 5) show P+1 to P+5, and the cycle after that shows the target taken from the branch's value field.
- R6: A branch issued while an earlier branch is still pending discards the earlier target and restarts the delay count. A pending branch whose redirect edge coincides with a new branch still redirects.
- R7: If several branches are issued in one cycle, the one in the highest-numbered issue slot supplies the target.
- R8: When two or more writes land on the same register at one edge, the later-issued one is kept. Later means a more recent issue cycle, or the higher slot within the same issue cycle. `wr_collision` is high for exactly the cycle after that edge and low otherwise.
- R9: Issues are accepted every cycle regardless of dependencies. A load followed one cycle later by a single-cycle write to the same register gives the single-cycle value first, and the load value overwrites it when the load lands.
- R10: A branch writes no register. The register named in its destination field keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_vld | input | NUM_ISSUE | Per-slot issue valid |
| iss_cls | input | NUM_ISSUE x 2 | Per-slot class: 0 single-cycle, 1 multiply, 2 load, 3 branch |
| iss_dst | input | NUM_ISSUE x log2(NUM_REGS) | Per-slot destination register |
| iss_val | input | NUM_ISSUE x DATA_W | Per-slot result value, or branch target |
| rd_addr | input | NUM_RD x log2(NUM_REGS) | Read port register numbers |
| rd_data | output | NUM_RD x DATA_W | Read port data, current committed contents |
| pc | output | DATA_W | Program counter |
| wr_collision | output | 1 | Same-register write collision at the previous edge |

## Verification
The bench builds the block with `NUM_ISSUE`=4, `NUM_RD`=2, `DATA_W`=16, `RESET_PC`=0x0100 and the default delays of 1, 4 and 5. Four slots are enough to drive same-cycle priority and multi-branch cycles. The narrow data width keeps mismatches easy to read. During the random phase, destinations are confined to eight registers, so writes from different classes and different issue cycles often land together. This exercises the age ordering between the single-cycle, multiply and load paths as well as the collision flag.

// File: rtl/wbs_pkg.sv
// Package wbs_pkg: operation class encoding shared by the scheduler and
// its checker. Assumes a 2-bit class field on every issue slot.
package wbs_pkg;
    typedef enum logic [1:0] {
        CLS_ALU    = 2'd0,
        CLS_MUL    = 2'd1,
        CLS_LOAD   = 2'd2,
        CLS_BRANCH = 2'd3
    } op_class_e;
endpackage

// File: rtl/wbs_delay_line.sv
// Module wbs_delay_line: carries N parallel write requests through DEPTH
// register stages. A request entering at one edge leaves stage 0 DEPTH-1
// edges later and is committed by the consumer at the edge after that.
// Assumes DEPTH >= 1; all entries in one stage share the same issue cycle.
module wbs_delay_line #(
    parameter int N     = 4,
    parameter int DEPTH = 1,
    parameter int AW    = 5,
    parameter int DW    = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N-1:0]           in_vld,
    input  logic [N-1:0][AW-1:0]   in_dst,
    input  logic [N-1:0][DW-1:0]   in_val,
    output logic [N-1:0]           out_vld,
    output logic [N-1:0][AW-1:0]   out_dst,
    output logic [N-1:0][DW-1:0]   out_val
);
    logic [DEPTH-1:0][N-1:0]         vld_q;
    logic [DEPTH-1:0][N-1:0][AW-1:0] dst_q;
    logic [DEPTH-1:0][N-1:0][DW-1:0] val_q;

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        if (k == DEPTH - 1) begin : g_head
            // Purpose: capture fresh requests into the last stage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q[k] <= '0;
                    dst_q[k] <= '0;
                    val_q[k] <= '0;
                end else begin
                    vld_q[k] <= in_vld;
                    dst_q[k] <= in_dst;
                    val_q[k] <= in_val;
                end
            end
        end else begin : g_body
            // Purpose: move requests one stage closer to the output.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q[k] <= '0;
                    dst_q[k] <= '0;
                    val_q[k] <= '0;
                end else begin
                    vld_q[k] <= vld_q[k+1];
                    dst_q[k] <= dst_q[k+1];
                    val_q[k] <= val_q[k+1];
                end
            end
        end
    end

    assign out_vld = vld_q[0];
    assign out_dst = dst_q[0];
    assign out_val = val_q[0];
endmodule

// File: rtl/wbs_regfile.sv
// Module wbs_regfile: register file with NWR write requests per edge,
// ordered by priority (a higher index wins). It flags any edge where two
// requests hit the same register. Reads are combinational from committed
// state, with no bypass. Assumes NREG == 2**AW.
module wbs_regfile #(
    parameter int NREG = 32,
    parameter int NWR  = 12,
    parameter int NRD  = 4,
    parameter int AW   = 5,
    parameter int DW   = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NWR-1:0]         wr_vld,
    input  logic [NWR-1:0][AW-1:0] wr_dst,
    input  logic [NWR-1:0][DW-1:0] wr_val,
    input  logic [NRD-1:0][AW-1:0] rd_addr,
    output logic [NRD-1:0][DW-1:0] rd_data,
    output logic                   collision
);
    logic [DW-1:0] mem_q [NREG];
    logic [DW-1:0] mem_d [NREG];
    logic          col_d;
    logic          col_q;

    // Purpose: resolve all landing writes, the highest-priority request last.
    always_comb begin
        for (int r = 0; r < NREG; r++) begin
            mem_d[r] = mem_q[r];
            for (int j = 0; j < NWR; j++) begin
                if (wr_vld[j] && (wr_dst[j] == AW'(r))) begin
                    mem_d[r] = wr_val[j];
                end
            end
        end
    end

    // Purpose: detect any pair of landing writes that share a destination.
    always_comb begin
        col_d = 1'b0;
        for (int i = 0; i < NWR; i++) begin
            for (int j = i + 1; j < NWR; j++) begin
                if (wr_vld[i] && wr_vld[j] && (wr_dst[i] == wr_dst[j])) begin
                    col_d = 1'b1;
                end
            end
        end
    end

    // Purpose: commit register contents and the collision flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) begin
                mem_q[r] <= '0;
            end
            col_q <= 1'b0;
        end else begin
            for (int r = 0; r < NREG; r++) begin
                mem_q[r] <= mem_d[r];
            end
            col_q <= col_d;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = mem_q[rd_addr[p]];
    end

    assign collision = col_q;
endmodule

// File: rtl/wbs_branch_unit.sv
// Module wbs_branch_unit: program counter with one pending branch.
// A branch sampled at an edge redirects the counter BR_SLOTS edges later.
// A newer branch overwrites the pending one. Within one cycle the highest
// slot wins. Assumes BR_SLOTS >= 1.
module wbs_branch_unit #(
    parameter int          N        = 4,
    parameter int          PW       = 32,
    parameter int          BR_SLOTS = 5,
    parameter int unsigned RESET_PC = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         br_vld,
    input  logic [N-1:0][PW-1:0] br_tgt,
    output logic [PW-1:0]        pc
);
    localparam int CW = $clog2(BR_SLOTS + 1);

    logic [PW-1:0] pc_q;
    logic [PW-1:0] tgt_q;
    logic [CW-1:0] cnt_q;
    logic          new_br;
    logic [PW-1:0] new_tgt;

    // Purpose: pick the target of the highest-slot branch this cycle.
    always_comb begin
        new_br  = 1'b0;
        new_tgt = '0;
        for (int s = 0; s < N; s++) begin
            if (br_vld[s]) begin
                new_br  = 1'b1;
                new_tgt = br_tgt[s];
            end
        end
    end

    // Purpose: step or redirect the counter and track the pending branch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= PW'(RESET_PC);
            tgt_q <= '0;
            cnt_q <= '0;
        end else begin
            pc_q <= (cnt_q == CW'(1)) ? tgt_q : pc_q + PW'(1);
            if (new_br) begin
                tgt_q <= new_tgt;
                cnt_q <= CW'(BR_SLOTS);
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end

    assign pc = pc_q;
endmodule

// File: rtl/lat_wb_sched.sv
// Module lat_wb_sched: fixed-latency writeback scheduler for an exposed
// pipeline. It routes each issued operation by class into a delay path,
// merges landing writes by age, and drives the branch-delayed counter.
// Assumes no interlock is needed, LOAD_SLOTS >= MUL_SLOTS >= 1, and
// NUM_REGS is a power of two.
module lat_wb_sched
    import wbs_pkg::*;
#(
    parameter int          NUM_ISSUE  = 8,
    parameter int          NUM_REGS   = 32,
    parameter int          NUM_RD     = 4,
    parameter int          DATA_W     = 32,
    parameter int          MUL_SLOTS  = 1,
    parameter int          LOAD_SLOTS = 4,
    parameter int          BR_SLOTS   = 5,
    parameter int unsigned RESET_PC   = 0
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [NUM_ISSUE-1:0]                    iss_vld,
    input  logic [NUM_ISSUE-1:0][1:0]               iss_cls,
    input  logic [NUM_ISSUE-1:0][$clog2(NUM_REGS)-1:0] iss_dst,
    input  logic [NUM_ISSUE-1:0][DATA_W-1:0]        iss_val,
    input  logic [NUM_RD-1:0][$clog2(NUM_REGS)-1:0] rd_addr,
    output logic [NUM_RD-1:0][DATA_W-1:0]           rd_data,
    output logic [DATA_W-1:0]                       pc,
    output logic                                    wr_collision
);
    localparam int AW  = $clog2(NUM_REGS);
    localparam int NWR = 3 * NUM_ISSUE;

    logic [NUM_ISSUE-1:0]             alu_vld;
    logic [NUM_ISSUE-1:0]             mul_vld;
    logic [NUM_ISSUE-1:0]             ld_vld;
    logic [NUM_ISSUE-1:0]             br_vld;
    logic [NUM_ISSUE-1:0]             mul_o_vld;
    logic [NUM_ISSUE-1:0][AW-1:0]     mul_o_dst;
    logic [NUM_ISSUE-1:0][DATA_W-1:0] mul_o_val;
    logic [NUM_ISSUE-1:0]             ld_o_vld;
    logic [NUM_ISSUE-1:0][AW-1:0]     ld_o_dst;
    logic [NUM_ISSUE-1:0][DATA_W-1:0] ld_o_val;
    logic [NWR-1:0]                   wr_vld;
    logic [NWR-1:0][AW-1:0]           wr_dst;
    logic [NWR-1:0][DATA_W-1:0]       wr_val;

    for (genvar s = 0; s < NUM_ISSUE; s++) begin : g_route
        assign alu_vld[s] = iss_vld[s] && (op_class_e'(iss_cls[s]) == CLS_ALU);
        assign mul_vld[s] = iss_vld[s] && (op_class_e'(iss_cls[s]) == CLS_MUL);
        assign ld_vld[s]  = iss_vld[s] && (op_class_e'(iss_cls[s]) == CLS_LOAD);
        assign br_vld[s]  = iss_vld[s] && (op_class_e'(iss_cls[s]) == CLS_BRANCH);
    end

    wbs_delay_line #(
        .N(NUM_ISSUE), .DEPTH(MUL_SLOTS), .AW(AW), .DW(DATA_W)
    ) i_mul_line (
        .clk(clk), .rst_n(rst_n),
        .in_vld(mul_vld), .in_dst(iss_dst), .in_val(iss_val),
        .out_vld(mul_o_vld), .out_dst(mul_o_dst), .out_val(mul_o_val)
    );

    wbs_delay_line #(
        .N(NUM_ISSUE), .DEPTH(LOAD_SLOTS), .AW(AW), .DW(DATA_W)
    ) i_ld_line (
        .clk(clk), .rst_n(rst_n),
        .in_vld(ld_vld), .in_dst(iss_dst), .in_val(iss_val),
        .out_vld(ld_o_vld), .out_dst(ld_o_dst), .out_val(ld_o_val)
    );

    // Priority order, lowest first: oldest (load), then multiply, then the
    // current single-cycle slots. Slot order is kept inside each group.
    assign wr_vld = {alu_vld, mul_o_vld, ld_o_vld};
    assign wr_dst = {iss_dst, mul_o_dst, ld_o_dst};
    assign wr_val = {iss_val, mul_o_val, ld_o_val};

    wbs_regfile #(
        .NREG(NUM_REGS), .NWR(NWR), .NRD(NUM_RD), .AW(AW), .DW(DATA_W)
    ) i_regfile (
        .clk(clk), .rst_n(rst_n),
        .wr_vld(wr_vld), .wr_dst(wr_dst), .wr_val(wr_val),
        .rd_addr(rd_addr), .rd_data(rd_data), .collision(wr_collision)
    );

    wbs_branch_unit #(
        .N(NUM_ISSUE), .PW(DATA_W), .BR_SLOTS(BR_SLOTS), .RESET_PC(RESET_PC)
    ) i_branch (
        .clk(clk), .rst_n(rst_n),
        .br_vld(br_vld), .br_tgt(iss_val), .pc(pc)
    );
endmodule

// File: rtl/wbs_checker.sv
// Module wbs_checker: port-level properties of lat_wb_sched, bound to it.
// It keeps its own branch age counter and idle counter from the issue ports.
module wbs_checker
    import wbs_pkg::*;
#(
    parameter int          NUM_ISSUE  = 8,
    parameter int          DATA_W     = 32,
    parameter int          NUM_REGS   = 32,
    parameter int          LOAD_SLOTS = 4,
    parameter int          BR_SLOTS   = 5,
    parameter int unsigned RESET_PC   = 0
) (
    input logic                                       clk,
    input logic                                       rst_n,
    input logic [NUM_ISSUE-1:0]                       iss_vld,
    input logic [NUM_ISSUE-1:0][1:0]                  iss_cls,
    input logic [NUM_ISSUE-1:0][$clog2(NUM_REGS)-1:0] iss_dst,
    input logic [NUM_ISSUE-1:0][DATA_W-1:0]           iss_val,
    input logic [DATA_W-1:0]                          pc,
    input logic                                       wr_collision
);
    logic              was_rst;
    logic              br_now;
    logic [DATA_W-1:0] br_tgt_now;
    logic              alu_pair;
    logic              age_vld;
    int                age_q;
    logic [DATA_W-1:0] tgt_q;
    int                idle_q;

    // Purpose: observe this cycle's branches and duplicate single-cycle writes.
    always_comb begin
        br_now     = 1'b0;
        br_tgt_now = '0;
        alu_pair   = 1'b0;
        for (int s = 0; s < NUM_ISSUE; s++) begin
            if (iss_vld[s] && op_class_e'(iss_cls[s]) == CLS_BRANCH) begin
                br_now     = 1'b1;
                br_tgt_now = iss_val[s];
            end
            for (int t = s + 1; t < NUM_ISSUE; t++) begin
                if (iss_vld[s] && iss_vld[t] &&
                    op_class_e'(iss_cls[s]) == CLS_ALU &&
                    op_class_e'(iss_cls[t]) == CLS_ALU &&
                    iss_dst[s] == iss_dst[t]) begin
                    alu_pair = 1'b1;
                end
            end
        end
    end

    // Purpose: track edges since the latest branch and since the latest issue.
    always_ff @(posedge clk) begin
        was_rst <= !rst_n;
        if (!rst_n) begin
            age_vld <= 1'b0;
            age_q   <= 0;
            tgt_q   <= '0;
            idle_q  <= 0;
        end else begin
            if (br_now) begin
                age_vld <= 1'b1;
                age_q   <= 0;
                tgt_q   <= br_tgt_now;
            end else if (age_vld && age_q < BR_SLOTS) begin
                age_q <= age_q + 1;
            end
            if (|iss_vld) begin
                idle_q <= 0;
            end else if (idle_q <= LOAD_SLOTS) begin
                idle_q <= idle_q + 1;
            end
        end
    end

    // R1
    always @(posedge clk) begin
        if (rst_n && was_rst) begin
            reset_state_chk: assert (pc == DATA_W'(RESET_PC) && !wr_collision);
        end
    end

    // R5
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(age_vld && age_q == BR_SLOTS - 1) |=> pc == $past(pc) + DATA_W'(1));

    // R6
    pc_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_vld && age_q == BR_SLOTS - 1) |=> pc == $past(tgt_q));

    // R8
    alu_collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alu_pair |=> wr_collision);

    // R8
    quiet_no_collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_q > LOAD_SLOTS) |-> !wr_collision);
endmodule

bind lat_wb_sched wbs_checker #(
    .NUM_ISSUE(NUM_ISSUE), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
    .LOAD_SLOTS(LOAD_SLOTS), .BR_SLOTS(BR_SLOTS), .RESET_PC(RESET_PC)
) i_wbs_checker (
    .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_cls(iss_cls),
    .iss_dst(iss_dst), .iss_val(iss_val), .pc(pc), .wr_collision(wr_collision)
);

// File: tb/test_lat_wb_sched.sv
`timescale 1ns/1ps
module test_lat_wb_sched;
    localparam int NI  = 4;
    localparam int NR  = 32;
    localparam int NRD = 2;
    localparam int DW  = 16;
    localparam int AW  = 5;
    localparam int MS  = 1;
    localparam int LS  = 4;
    localparam int BS  = 5;
    localparam logic [DW-1:0] RPC = 16'h0100;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic [NI-1:0]          iss_vld;
    logic [NI-1:0][1:0]     iss_cls;
    logic [NI-1:0][AW-1:0]  iss_dst;
    logic [NI-1:0][DW-1:0]  iss_val;
    logic [NRD-1:0][AW-1:0] rd_addr;
    logic [NRD-1:0][DW-1:0] rd_data;
    logic [DW-1:0]          pc;
    logic                   wr_collision;

    always #2 clk = ~clk;

    lat_wb_sched #(
        .NUM_ISSUE(NI), .NUM_REGS(NR), .NUM_RD(NRD), .DATA_W(DW),
        .MUL_SLOTS(MS), .LOAD_SLOTS(LS), .BR_SLOTS(BS), .RESET_PC(32'h0100)
    ) i_lat_wb_sched (
        .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_cls(iss_cls),
        .iss_dst(iss_dst), .iss_val(iss_val), .rd_addr(rd_addr),
        .rd_data(rd_data), .pc(pc), .wr_collision(wr_collision)
    );

    // Behavioural reference: pending writes as a queue with landing edges.
    typedef struct {
        int          land;
        int          dst;
        logic [DW-1:0] val;
    } pw_t;

    pw_t           pq[$];
    logic [DW-1:0] m_reg [NR];
    logic [DW-1:0] m_pc;
    logic [DW-1:0] m_br_tgt;
    bit            m_br_pend;
    int            m_br_land;
    bit            m_col;
    int            ec;
    int            n_checks = 0;
    int            n_fail   = 0;
    string         phase    = "R1";

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s (%s): actual %h expected %h", tag, phase, act, exp);
        end
    endtask

    task automatic model_edge();
        pw_t keep[$];
        int  hits [NR];
        for (int s = 0; s < NI; s++) begin
            if (iss_vld[s]) begin
                pw_t e;
                e.dst = int'(iss_dst[s]);
                e.val = iss_val[s];
                e.land = -1;
                if (iss_cls[s] == 2'd0) e.land = ec;
                if (iss_cls[s] == 2'd1) e.land = ec + MS;
                if (iss_cls[s] == 2'd2) e.land = ec + LS;
                if (e.land >= 0) pq.push_back(e);
            end
        end
        foreach (hits[r]) hits[r] = 0;
        m_col = 1'b0;
        foreach (pq[i]) begin
            if (pq[i].land == ec) begin
                m_reg[pq[i].dst] = pq[i].val;
                hits[pq[i].dst]++;
                if (hits[pq[i].dst] > 1) m_col = 1'b1;
            end else begin
                keep.push_back(pq[i]);
            end
        end
        pq = keep;
        if (m_br_pend && m_br_land == ec) begin
            m_pc = m_br_tgt;
            m_br_pend = 1'b0;
        end else begin
            m_pc = m_pc + 1'b1;
        end
        for (int s = 0; s < NI; s++) begin
            if (iss_vld[s] && iss_cls[s] == 2'd3) begin
                m_br_pend = 1'b1;
                m_br_land = ec + BS;
                m_br_tgt  = iss_val[s];
            end
        end
        ec++;
    endtask

    task automatic compare_all();
        check("R5 pc", pc, m_pc);
        check("R8 collision", {15'd0, wr_collision}, {15'd0, m_col});
        check("R9 read0", rd_data[0], m_reg[rd_addr[0]]);
        check("R9 read1", rd_data[1], m_reg[rd_addr[1]]);
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        #1;
        compare_all();
        rd_addr[0] = AW'(ec);
    endtask

    task automatic clear_issue();
        iss_vld = '0;
        iss_cls = '0;
        iss_dst = '0;
        iss_val = '0;
    endtask

    task automatic put(int s, logic [1:0] c, int d, logic [DW-1:0] v);
        iss_vld[s] = 1'b1;
        iss_cls[s] = c;
        iss_dst[s] = AW'(d);
        iss_val[s] = v;
    endtask

    initial begin
        #(4 * 60000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] p0;
        rst_n = 1'b0;
        clear_issue();
        rd_addr = '0;
        repeat (3) @(posedge clk);
        #1;
        foreach (m_reg[r]) m_reg[r] = '0;
        m_pc = RPC; m_br_pend = 1'b0; m_br_land = 0; m_br_tgt = '0;
        m_col = 1'b0; ec = 0;
        // R1: reset state
        check("R1 pc", pc, RPC);
        check("R1 collision", {15'd0, wr_collision}, 16'd0);
        check("R1 reg", rd_data[0], 16'd0);
        rst_n = 1'b1;

        // R2: single-cycle write visible next cycle
        phase = "R2";
        clear_issue(); put(0, 2'd0, 1, 16'h1111); rd_addr[1] = 5'd1;
        step(); clear_issue();
        check("R2 alu visible", rd_data[1], 16'h1111);

        // R3: multiply keeps old value for one cycle
        phase = "R3";
        put(1, 2'd1, 2, 16'h2222); rd_addr[1] = 5'd2;
        step(); clear_issue();
        check("R3 old during slot", rd_data[1], 16'h0000);
        step();
        check("R3 new after slot", rd_data[1], 16'h2222);

        // R4: load keeps old value for four cycles
        phase = "R4";
        put(2, 2'd2, 1, 16'h3333); rd_addr[1] = 5'd1;
        step(); clear_issue();
        for (int k = 0; k < 3; k++) begin
            check("R4 old during slots", rd_data[1], 16'h1111);
            step();
        end
        check("R4 old last slot", rd_data[1], 16'h1111);
        step();
        check("R4 new after slots", rd_data[1], 16'h3333);

        // R5 and R10: branch delay slots, no register write
        phase = "R5";
        p0 = pc;
        put(3, 2'd3, 4, 16'h0400); rd_addr[1] = 5'd4;
        step(); clear_issue();
        check("R10 branch no write", rd_data[1], 16'h0000);
        for (int k = 2; k <= BS; k++) begin
            check("R5 delay slot pc", pc, p0 + DW'(k - 1));
            step();
        end
        check("R5 last slot pc", pc, p0 + DW'(BS));
        step();
        check("R5 redirect", pc, 16'h0400);

        // R6: second branch replaces the pending one
        phase = "R6";
        put(0, 2'd3, 0, 16'h0A00);
        step(); clear_issue();
        step();
        put(1, 2'd3, 0, 16'h0B00);
        step(); clear_issue();
        for (int k = 0; k < BS; k++) step();
        check("R6 replaced target", pc, 16'h0B00);

        // R7: highest slot supplies target
        phase = "R7";
        put(1, 2'd3, 0, 16'h0C00); put(3, 2'd3, 0, 16'h0D00);
        step(); clear_issue();
        for (int k = 0; k < BS; k++) step();
        check("R7 highest slot target", pc, 16'h0D00);

        // R8: same-cycle collision, higher slot wins
        phase = "R8";
        put(0, 2'd0, 5, 16'h5A5A); put(2, 2'd0, 5, 16'h5B5B); rd_addr[1] = 5'd5;
        step(); clear_issue();
        check("R8 slot priority", rd_data[1], 16'h5B5B);
        check("R8 flag set", {15'd0, wr_collision}, 16'd1);
        step();
        check("R8 flag one cycle", {15'd0, wr_collision}, 16'd0);
        // R8: multiply issued earlier loses to single-cycle issued later
        put(3, 2'd1, 6, 16'h6A6A); rd_addr[1] = 5'd6;
        step(); clear_issue();
        put(0, 2'd0, 6, 16'h6B6B);
        step(); clear_issue();
        check("R8 age priority", rd_data[1], 16'h6B6B);
        check("R8 cross-class flag", {15'd0, wr_collision}, 16'd1);

        // R9: load then single-cycle to same register, no stall
        phase = "R9";
        put(1, 2'd2, 7, 16'h7A7A); rd_addr[1] = 5'd7;
        step(); clear_issue();
        put(2, 2'd0, 7, 16'h7B7B);
        step(); clear_issue();
        check("R9 alu first", rd_data[1], 16'h7B7B);
        step(); step();
        check("R9 alu before load", rd_data[1], 16'h7B7B);
        step();
        check("R9 load lands later", rd_data[1], 16'h7A7A);

        // R9: dense random traffic against the reference model
        for (int c = 0; c < 400; c++) begin
            clear_issue();
            for (int s = 0; s < NI; s++) begin
                if ($urandom_range(1, 0) == 1) begin
                    put(s, 2'($urandom_range(3, 0)), $urandom_range(7, 0),
                        16'($urandom));
                end
            end
            rd_addr[1] = AW'($urandom_range(7, 0));
            step();
        end
        clear_issue();
        for (int k = 0; k < 8; k++) step();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule